// File: doc/BRIEF.md
# Video Bridge I2C Register Target

This block is the control-port target of a video bridge. A host on a two-wire I2C bus addresses it at a 7-bit address supplied on `dev_addr_i`. The host writes one byte to set an internal register pointer, then reads or writes consecutive registers, with the pointer advancing after every byte. The register space is small. It holds a fixed identification byte, a fixed interrupt-status byte, and a system control register. All other offsets read as zero and ignore writes.

The system control register carries the handshake that hands the shared bus to the display-identification path. The host sets the request bit to make a request pending. If it sets the grant bit in the same byte, the block enters pass-through mode and raises `ddc_mode_o`. External logic uses this output to steer the bus to the display-data responder. The stop that closes the entering transaction leaves the mode in place. The stop after that drops it. Clearing the request bit cancels both the request and the mode at once.

Both bus lines pass through two synchronising flip-flops and are sampled at the system clock. SDA is driven only low, through `sda_oe_o`.

Top module: `i2c_bridge_regs`

## Requirements
- R1: The block ACKs (holds SDA low in the ninth clock) an address byte whose upper 7 bits equal `dev_addr_i`. It does not ACK any other address, and it stays silent for every byte until the next start.
- R2: In a write transaction, every data byte is ACKed.
- R3: The first data byte after a matched write address (R/W bit 0) loads the register pointer and is not written to any register.
- R4: The pointer increments by one after every data byte read or written (not the pointer byte). It wraps from 0xFF to 0x00. A read with no pointer byte starts at the current pointer.
- R5: Offset 0x1B reads 0xB0 and offset 0x3D reads 0x04. Every other offset except 0x1A, including 0x3C, reads 0x00. Writes to these offsets change nothing.
- R6: A write of 0x1A with bit 2 set makes a request pending. Offset 0x1A reads 0x06 while a request is pending and 0x00 otherwise.
- R7: A write of 0x1A with bits 2 and 1 both set raises `ddc_mode_o`, visible by the end of that byte's ACK clock.
- R8: A write of 0x1A with bit 2 clear clears the pending request and drops `ddc_mode_o`.
- R9: The first stop after entering pass-through mode keeps `ddc_mode_o` high. A later stop drops it, and the request stays pending.
- R10: When the controller NACKs a read byte, the block releases SDA and drives nothing until a start or stop. A repeated start begins a new address phase.
- R11: Reset clears the pointer, the pending request and the mode. After reset `ddc_mode_o` and `sda_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 7 | Device address matched by the target |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when high |
| ddc_mode_o | output | 1 | Pass-through mode flag |
| | | | |

## Verification
A wrong pointer shows up on the very next byte read: it returns the value of a neighbouring offset. A full sweep of all 256 offsets, read back in one burst, catches any misplaced constant or failed wrap within one byte. A wrong request or skip-stop flag shows up either as a wrong 0x1A readback or as `ddc_mode_o` changing one stop too early or too late. The bench therefore samples the mode after each ACK and after each stop. A stuck drive enable shows as SDA held low during clocks that follow a NACK or a mismatched address.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OFS_SYS_CTRL = 8'h1A;
  localparam logic [BYTE_W-1:0] OFS_CHIP_ID  = 8'h1B;
  localparam logic [BYTE_W-1:0] OFS_IRQ_STAT = 8'h3D;

  localparam logic [BYTE_W-1:0] VAL_CHIP_ID  = 8'hB0;
  localparam logic [BYTE_W-1:0] VAL_IRQ_STAT = 8'h04;

  localparam int unsigned BIT_BUS_REQ = 2;
  localparam int unsigned BIT_BUS_GNT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s_o    = scl_ff[SYNC_STAGES-1];
  assign sda_s_o    = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              sda_oe_o,
  output logic              addr_wr_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_stb_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  bus_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, nack_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      oe_q      <= 1'b0;
      addr_wr_o <= 1'b0;
      wr_stb_o  <= 1'b0;
      rd_stb_o  <= 1'b0;
    end else begin
      addr_wr_o <= 1'b0;
      wr_stb_o  <= 1'b0;
      rd_stb_o  <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              if (state_q == ST_WR) begin
                wr_stb_o <= 1'b1;
                oe_q     <= 1'b1;
                state_q  <= ST_WR_ACK;
              end else if (sh_q[BYTE_W-1:1] == dev_addr_i) begin
                rw_q      <= sh_q[0];
                addr_wr_o <= ~sh_q[0];
                oe_q      <= 1'b1;
                state_q   <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q    <= rd_byte_i;
                oe_q    <= ~rd_byte_i[BYTE_W-1];
                state_q <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == CNT_FULL) begin
                oe_q     <= 1'b0;
                rd_stb_o <= 1'b1;
                state_q  <= ST_RD_ACK;
              end else begin
                oe_q <= ~sh_q[~cnt_q[2:0]];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_s_i;
            end else if (scl_fall_i) begin
              if (!nack_q) begin
                sh_q    <= rd_byte_i;
                oe_q    <= ~rd_byte_i[BYTE_W-1];
                cnt_q   <= '0;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_data_o = sh_q;

  // R1 R2
  sda_drive_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s_i);
  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  // R10
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> !sda_oe_o);
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile
  import bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_stb_i,
  input  logic              stop_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              ddc_mode_o
);
  logic [BYTE_W-1:0] ptr_q;
  logic first_q, req_q, skip_q, ddc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      first_q <= 1'b0;
      req_q   <= 1'b0;
      skip_q  <= 1'b0;
      ddc_q   <= 1'b0;
    end else begin
      if (addr_wr_i) first_q <= 1'b1;
      if (stop_i) begin
        if (skip_q) skip_q <= 1'b0;
        else        ddc_q  <= 1'b0;
      end
      if (wr_stb_i) begin
        if (first_q) begin
          ptr_q   <= wr_data_i;
          first_q <= 1'b0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == OFS_SYS_CTRL) begin
            if (wr_data_i[BIT_BUS_REQ]) begin
              req_q <= 1'b1;
              if (wr_data_i[BIT_BUS_GNT]) begin
                ddc_q  <= 1'b1;
                skip_q <= 1'b1;
              end
            end else begin
              req_q <= 1'b0;
              ddc_q <= 1'b0;
            end
          end
        end
      end else if (rd_stb_i) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (ptr_q)
      OFS_SYS_CTRL: rd_byte_o = req_q ? BYTE_W'((1 << BIT_BUS_REQ) | (1 << BIT_BUS_GNT)) : '0;
      OFS_CHIP_ID:  rd_byte_o = VAL_CHIP_ID;
      OFS_IRQ_STAT: rd_byte_o = VAL_IRQ_STAT;
      default:      rd_byte_o = '0;
    endcase
  end

  assign ddc_mode_o = ddc_q;

  // R4
  rd_ptr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> ptr_q == $past(ptr_q) + 8'd1);
  // R3
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && first_q) |=> ptr_q == $past(wr_data_i));
  // R9
  ddc_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddc_q |-> req_q);
  // R7
  ddc_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ddc_q) |-> $past(wr_stb_i));
endmodule

// File: rtl/i2c_bridge_regs.sv
module i2c_bridge_regs
  import bridge_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              ddc_mode_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic addr_wr, wr_stb, rd_stb;
  logic [BYTE_W-1:0] wr_data, rd_byte;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_target_engine #(.ADDR_W(ADDR_W)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_addr_i (dev_addr_i),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_byte_i  (rd_byte),
    .sda_oe_o   (sda_oe_o),
    .addr_wr_o  (addr_wr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .rd_stb_o   (rd_stb)
  );

  bridge_regfile i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_wr_i  (addr_wr),
    .wr_stb_i   (wr_stb),
    .wr_data_i  (wr_data),
    .rd_stb_i   (rd_stb),
    .stop_i     (stop_det),
    .rd_byte_o  (rd_byte),
    .ddc_mode_o (ddc_mode_o)
  );
endmodule

// File: tb/test_i2c_bridge_regs.sv
module test_i2c_bridge_regs;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int WDOG = 150000;
  localparam logic [6:0] DEV = 7'h39;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, ddc_mode;
  logic sda_line;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_bridge_regs i_i2c_bridge_regs (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .dev_addr_i (DEV),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .ddc_mode_o (ddc_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic bit_x(input logic b, output logic s);
    sda_m = b; waitq();
    scl_m = 1'b1; waitq();
    s = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(d[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, s);
      d[i] = s;
    end
    bit_x(~m_ack, s);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] ofs, input bit req);
    case (ofs)
      8'h1A:   return req ? 8'h06 : 8'h00;
      8'h1B:   return 8'hB0;
      8'h3D:   return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  task automatic reg_write(input logic [7:0] ofs, input logic [7:0] d, input string req);
    logic a;
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk({req, " addr ack"}, a, 1);
    wr_byte(ofs, a);         chk({req, " ptr ack"}, a, 1);
    wr_byte(d, a);           chk({req, " data ack"}, a, 1);
  endtask

  task automatic reg_read(input logic [7:0] ofs, output logic [7:0] d);
    logic a;
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(ofs, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a, s;
    logic [7:0] d;
    bit hold_low;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ddc after reset", ddc_mode, 0);
    chk("R11 oe after reset", sda_oe, 0);

    // R1 mismatched addresses
    bus_start();
    wr_byte({7'h38, 1'b0}, a); chk("R1 nack addr 0x38", a, 0);
    wr_byte(8'h1A, a);         chk("R1 silent after mismatch", a, 0);
    bus_stop();
    bus_start();
    wr_byte({7'h79, 1'b1}, a); chk("R1 nack addr 0x79", a, 0);
    bus_stop();

    // R1 R2 R3 R5 chip id via repeated start, then R4 next offset
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk("R1 ack own addr", a, 1);
    wr_byte(8'h1B, a);       chk("R2 ptr byte ack", a, 1);
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk("R1 ack read addr", a, 1);
    rd_byte(1'b1, d);        chk("R5 chip id", d, 8'hB0);
    rd_byte(1'b0, d);        chk("R4 next offset 0x1C", d, 8'h00);
    // R10 silent after NACK
    hold_low = 1'b0;
    for (int i = 0; i < 9; i++) begin
      bit_x(1'b1, s);
      if (!s) hold_low = 1'b1;
    end
    chk("R10 released after nack", hold_low, 0);
    bus_stop();

    // R3 R4 R5 ignored write, pointer advances, current-address read
    reg_write(8'h3C, 8'h55, "R3");
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b1, d); chk("R4 current read 0x3D", d, 8'h04);
    rd_byte(1'b0, d); chk("R5 0x3E reads zero", d, 8'h00);
    bus_stop();
    reg_read(8'h3C, d); chk("R5 0x3C write ignored", d, 8'h00);

    // R6 request only
    reg_write(8'h1A, 8'h04, "R6");
    chk("R6 no mode on request only", ddc_mode, 0);
    bus_stop();
    reg_read(8'h1A, d); chk("R6 pending readback", d, 8'h06);

    // R7 R9 enter mode, stop handling
    reg_write(8'h1A, 8'h06, "R7");
    chk("R7 mode entered", ddc_mode, 1);
    bus_stop();
    chk("R9 first stop keeps mode", ddc_mode, 1);
    reg_read(8'h1B, d); chk("R5 chip id in mode", d, 8'hB0);
    chk("R9 second stop drops mode", ddc_mode, 0);
    reg_read(8'h1A, d); chk("R9 request stays pending", d, 8'h06);

    // R4 R7 write auto-increment into 0x1A, then R8 cancel
    reg_write(8'h19, 8'h00, "R4");
    wr_byte(8'h06, a); chk("R2 second data ack", a, 1);
    chk("R4 R7 incremented write enters mode", ddc_mode, 1);
    bus_stop();
    reg_write(8'h1A, 8'h00, "R8");
    chk("R8 mode cleared", ddc_mode, 0);
    bus_stop();
    reg_read(8'h1A, d); chk("R8 request cleared", d, 8'h00);

    // R4 R5 full sweep with wrap
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h00, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    for (int i = 0; i <= 256; i++) begin
      rd_byte(i < 256, d);
      chk($sformatf("R4 R5 sweep offset 0x%0h", i & 255), d, exp_reg(8'(i), 1'b0));
    end
    bus_stop();

    // R11 reset in mode
    reg_write(8'h1A, 8'h06, "R11");
    bus_stop();
    chk("R11 mode before reset", ddc_mode, 1);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 mode after reset", ddc_mode, 0);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d); chk("R11 pointer at zero", d, 8'h00);
    bus_stop();
    reg_read(8'h1A, d); chk("R11 request cleared", d, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule